// File: doc/BRIEF.md
# Timer Compare Interrupt Unit

This block watches a free-running tick count and raises an interrupt request when the count reaches a target that software has written into a compare register. The compare register is one bit wider than the count. Its top bit is a disable flag, and the bits below it hold the target. There are two channels built from the same compare logic. The supervisor channel turns a hit into a one-cycle set request on bit 16 of the soft-interrupt vector. The hypervisor channel turns a hit into a one-cycle set request for the hypervisor interrupt-pending flag.

Every write to a channel's compare register replaces the previous target and decides again whether the channel is armed. A write arms the channel only when the disable flag is clear and the target is strictly greater than the count in the write cycle. An armed channel fires once, when the count equals the target exactly, and is then disarmed. The count itself and the logic that delivers the interrupt are outside this block.

Top module: `tmu_top`

## Requirements
- R1: Out of reset, both compare registers read as disabled (top bit 1, target 0), and every match, soft-interrupt and pending-set output is 0.
- R2: The cycle after a compare write, the channel's read port returns exactly the written value.
- R3: A write with the top bit 0 and a target greater than the count in the write cycle arms the channel. The channel's match bit (bit 0 supervisor, bit 1 hypervisor) is then 1 for one cycle, in the cycle after the first cycle in which the count equals the target.
- R4: A write whose target is less than or equal to the count in the write cycle arms nothing, so no pulse follows even when the count later wraps round to the target.
- R5: A write with the top bit 1 cancels any armed target, and no pulse follows.
- R6: A new write replaces the armed target: the old target passes with no pulse, and the new target fires.
- R7: An armed channel fires at most once per write. A second pass of the count through the target produces no pulse.
- R8: A supervisor pulse appears on the soft-interrupt set vector as bit 16 alone. No other bit of that vector is ever set.
- R9: A hypervisor pulse appears as the pending-set output being 1. The hypervisor channel never drives the soft-interrupt vector.
- R10: If the hypervisor thread is halted in the cycle of equality, the hypervisor channel gives no pulse and disarms. Halting has no effect on the supervisor channel.
- R11: When a compare write falls in the same cycle as an equality, the write wins. The old target gives no pulse, and the new target is armed or not by the rule of R3.
- R12: The two channels are independent. Both may fire in the same cycle, and a write to one does not disturb the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | CNT_W | Free-running tick count |
| sup_wr_i | input | 1 | Write strobe, supervisor compare register |
| sup_wdata_i | input | CNT_W+1 | Write value: top bit disables, low bits hold the target |
| sup_cmp_o | output | CNT_W+1 | Supervisor compare register read value |
| hyp_wr_i | input | 1 | Write strobe, hypervisor compare register |
| hyp_wdata_i | input | CNT_W+1 | Write value: top bit disables, low bits hold the target |
| hyp_cmp_o | output | CNT_W+1 | Hypervisor compare register read value |
| hyp_halted_i | input | 1 | Hypervisor thread is halted |
| match_o | output | 2 | One-cycle match pulses, bit 0 supervisor, bit 1 hypervisor |
| swint_set_o | output | SWINT_W | Soft-interrupt set request vector |
| hintp_set_o | output | 1 | Hypervisor interrupt-pending set request |

## Verification
Two events can land in the same cycle: a compare write, and the equality of the count with the target already armed. The bench arms a target, then writes a new target in exactly the cycle the count reaches the old one. It expects no pulse at the old target and one pulse at the new target. A halt can also coincide with an equality. That case is judged by looking for a pulse on either channel, both at the equality and over a full wrap of the count afterwards. A swept set of write counts and targets, on a narrow count, checks the arm rule and the fire-once rule arithmetically.

// File: rtl/tmu_pkg.sv
// Shared types for the timer compare unit.
// Assumes channel 0 is the supervisor channel and channel 1 is the hypervisor channel.
package tmu_pkg;
    typedef enum logic {
        CH_SUP = 1'b0,
        CH_HYP = 1'b1
    } chan_kind_e;

    localparam int NUM_CH = 2;
endpackage

// File: rtl/tmu_core.sv
// One compare channel: holds the compare register, arms on each write,
// and emits a registered one-cycle pulse on exact equality with the count.
// Assumes the count steps by one each cycle, because a skipped target is missed.
module tmu_core #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tick_i,
    input  logic             wr_i,
    input  logic [CNT_W:0]   wdata_i,
    input  logic             enable_i,
    output logic [CNT_W:0]   cmp_o,
    output logic             pulse_o
);
    localparam int DIS_BIT = CNT_W;

    logic [CNT_W:0] cmp_q;
    logic           armed_q;
    logic           pulse_q;
    logic           hit;

    // Equality between the armed target and the current count
    assign hit = armed_q && (cmp_q[CNT_W-1:0] == tick_i);

    // Compare register: holds the last written value, and resets to disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= {1'b1, {CNT_W{1'b0}}};
        end else if (wr_i) begin
            cmp_q <= wdata_i;
        end
    end

    // Arm state: each write decides it again, and an equality clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (wr_i) begin
            armed_q <= !wdata_i[DIS_BIT] && (wdata_i[CNT_W-1:0] > tick_i);
        end else if (hit) begin
            armed_q <= 1'b0;
        end
    end

    // Match pulse: fires on equality unless a write, the disable bit or the enable blocks it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= hit && !wr_i && !cmp_q[DIS_BIT] && enable_i;
        end
    end

    assign cmp_o   = cmp_q;
    assign pulse_o = pulse_q;
endmodule

// File: rtl/tmu_route.sv
// Maps one channel's match pulse onto its interrupt target.
// The supervisor kind drives a single bit of the soft-interrupt set vector.
// The hypervisor kind drives the pending-set flag.
module tmu_route #(
    parameter tmu_pkg::chan_kind_e KIND = tmu_pkg::CH_SUP,
    parameter int SWINT_W   = 17,
    parameter int SWINT_BIT = 16
) (
    input  logic               pulse_i,
    output logic [SWINT_W-1:0] swint_o,
    output logic               hint_o
);
    generate
        if (KIND == tmu_pkg::CH_SUP) begin : g_sup
            // Supervisor: request on one soft-interrupt bit only
            always_comb begin
                swint_o            = '0;
                swint_o[SWINT_BIT] = pulse_i;
            end
            assign hint_o = 1'b0;
        end else begin : g_hyp
            // Hypervisor: request on the pending flag only
            assign swint_o = '0;
            assign hint_o  = pulse_i;
        end
    endgenerate
endmodule

// File: rtl/tmu_top.sv
// Timer compare unit with two channels (supervisor and hypervisor) that share one core design.
// Assumes hyp_halted_i is synchronous to clk.
module tmu_top #(
    parameter int CNT_W     = 63,
    parameter int SWINT_W   = 17,
    parameter int SWINT_BIT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   tick_i,
    input  logic               sup_wr_i,
    input  logic [CNT_W:0]     sup_wdata_i,
    output logic [CNT_W:0]     sup_cmp_o,
    input  logic               hyp_wr_i,
    input  logic [CNT_W:0]     hyp_wdata_i,
    output logic [CNT_W:0]     hyp_cmp_o,
    input  logic               hyp_halted_i,
    output logic [1:0]         match_o,
    output logic [SWINT_W-1:0] swint_set_o,
    output logic               hintp_set_o
);
    import tmu_pkg::*;

    localparam int CMP_W = CNT_W + 1;

    logic [NUM_CH-1:0] wr_a;
    logic [CMP_W-1:0]  wd_a   [NUM_CH];
    logic [CMP_W-1:0]  cmp_a  [NUM_CH];
    logic [NUM_CH-1:0] pulse_a;
    logic [SWINT_W-1:0] sw_a  [NUM_CH];
    logic [NUM_CH-1:0] hint_a;

    // Gather the per-channel write ports into arrays
    assign wr_a[CH_SUP] = sup_wr_i;
    assign wr_a[CH_HYP] = hyp_wr_i;
    assign wd_a[CH_SUP] = sup_wdata_i;
    assign wd_a[CH_HYP] = hyp_wdata_i;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            localparam chan_kind_e KIND = chan_kind_e'(g);
            logic en;

            // Only the hypervisor channel is blocked by a halted thread
            assign en = (KIND == CH_HYP) ? !hyp_halted_i : 1'b1;

            tmu_core #(.CNT_W(CNT_W)) u_core (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick_i   (tick_i),
                .wr_i     (wr_a[g]),
                .wdata_i  (wd_a[g]),
                .enable_i (en),
                .cmp_o    (cmp_a[g]),
                .pulse_o  (pulse_a[g])
            );

            tmu_route #(.KIND(KIND), .SWINT_W(SWINT_W), .SWINT_BIT(SWINT_BIT)) u_route (
                .pulse_i (pulse_a[g]),
                .swint_o (sw_a[g]),
                .hint_o  (hint_a[g])
            );
        end
    endgenerate

    // Merge the channel requests onto the shared outputs
    always_comb begin
        swint_set_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            swint_set_o = swint_set_o | sw_a[i];
        end
    end

    assign hintp_set_o = |hint_a;
    assign match_o     = pulse_a;
    assign sup_cmp_o   = cmp_a[CH_SUP];
    assign hyp_cmp_o   = cmp_a[CH_HYP];
endmodule

// File: rtl/tmu_checker.sv
// Property checker for tmu_top, attached with bind. It only observes ports.
module tmu_checker #(
    parameter int CNT_W     = 63,
    parameter int SWINT_W   = 17,
    parameter int SWINT_BIT = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CNT_W-1:0]   tick_i,
    input logic               sup_wr_i,
    input logic [CNT_W:0]     sup_wdata_i,
    input logic [CNT_W:0]     sup_cmp_o,
    input logic               hyp_wr_i,
    input logic [CNT_W:0]     hyp_wdata_i,
    input logic [CNT_W:0]     hyp_cmp_o,
    input logic               hyp_halted_i,
    input logic [1:0]         match_o,
    input logic [SWINT_W-1:0] swint_set_o,
    input logic               hintp_set_o
);
    AST_SUP_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        sup_wr_i |=> (sup_cmp_o == $past(sup_wdata_i))); // R2

    AST_HYP_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        hyp_wr_i |=> (hyp_cmp_o == $past(hyp_wdata_i))); // R2

    AST_SUP_PULSE_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        match_o[0] |-> ($past(tick_i) == $past(sup_cmp_o[CNT_W-1:0])
                        && !$past(sup_cmp_o[CNT_W]) && !$past(sup_wr_i))); // R3

    AST_HYP_PULSE_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        match_o[1] |-> ($past(tick_i) == $past(hyp_cmp_o[CNT_W-1:0])
                        && !$past(hyp_cmp_o[CNT_W]) && !$past(hyp_wr_i))); // R3

    AST_DISABLE_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_wr_i && sup_wdata_i[CNT_W]) |=> !match_o[0]); // R5

    AST_SUP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        match_o[0] |=> !match_o[0]); // R7

    AST_HYP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        match_o[1] |=> !match_o[1]); // R7

    AST_SWINT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(swint_set_o) <= 1) && (swint_set_o[SWINT_BIT] == match_o[0])); // R8

    AST_HINT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        hintp_set_o == match_o[1]); // R9

    AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        match_o[1] |-> !$past(hyp_halted_i)); // R10
endmodule

bind tmu_top tmu_checker #(
    .CNT_W(CNT_W), .SWINT_W(SWINT_W), .SWINT_BIT(SWINT_BIT)
) u_tmu_checker (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .sup_wr_i(sup_wr_i), .sup_wdata_i(sup_wdata_i), .sup_cmp_o(sup_cmp_o),
    .hyp_wr_i(hyp_wr_i), .hyp_wdata_i(hyp_wdata_i), .hyp_cmp_o(hyp_cmp_o),
    .hyp_halted_i(hyp_halted_i), .match_o(match_o),
    .swint_set_o(swint_set_o), .hintp_set_o(hintp_set_o)
);

// File: tb/test_tmu_top.sv
`timescale 1ns/1ps
module test_tmu_top;
    localparam int W  = 8;
    localparam int SW = 17;
    localparam int SB = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [W-1:0]  tick;
    logic          sup_wr, hyp_wr, halted;
    logic [W:0]    sup_wd, hyp_wd, sup_cmp, hyp_cmp;
    logic [1:0]    match;
    logic [SW-1:0] swint;
    logic          hint;

    int n_chk = 0, n_fail = 0;
    int cnt_sup, cnt_hyp, last_sup, last_hyp, route_err;

    always #4 clk = ~clk;

    tmu_top #(.CNT_W(W), .SWINT_W(SW), .SWINT_BIT(SB)) i_tmu_top (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .sup_wr_i(sup_wr), .sup_wdata_i(sup_wd), .sup_cmp_o(sup_cmp),
        .hyp_wr_i(hyp_wr), .hyp_wdata_i(hyp_wd), .hyp_cmp_o(hyp_cmp),
        .hyp_halted_i(halted), .match_o(match),
        .swint_set_o(swint), .hintp_set_o(hint)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        cnt_sup = 0; cnt_hyp = 0; last_sup = -1; last_hyp = -1; route_err = 0;
    endtask

    // One cycle: hold tick at v with the current write strobes, then observe after the edge
    task automatic step(input int v);
        tick = W'(v);
        @(negedge clk);
        if (match[0]) begin cnt_sup++; last_sup = v; end
        if (match[1]) begin cnt_hyp++; last_hyp = v; end
        if (swint !== (match[0] ? (SW'(1) << SB) : SW'(0))) route_err++;
        if (hint !== match[1]) route_err++;
        sup_wr = 1'b0;
        hyp_wr = 1'b0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_up();
    end

    initial begin
        rst_n = 1'b0; tick = '0; sup_wr = 0; hyp_wr = 0; halted = 0;
        sup_wd = '0; hyp_wd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clear_counts();

        // R1: reset state
        chk(sup_cmp == 9'h100, "R1 sup cmp", sup_cmp, 9'h100);
        chk(hyp_cmp == 9'h100, "R1 hyp cmp", hyp_cmp, 9'h100);
        chk(match == 2'b00 && swint == '0 && !hint, "R1 outputs", {match, hint}, 0);

        // R2: readback
        sup_wr = 1; sup_wd = 9'h1AB; step(0);
        chk(sup_cmp == 9'h1AB, "R2 sup readback", sup_cmp, 9'h1AB);
        hyp_wr = 1; hyp_wd = 9'h05C; step(200);
        chk(hyp_cmp == 9'h05C, "R2 hyp readback", hyp_cmp, 9'h05C);

        // Sweep: R3, R4, R7, R8, R9, R12
        for (int ci = 0; ci < 3; ci++) begin
            int c;
            c = (ci == 0) ? 0 : (ci == 1) ? 100 : 250;
            for (int i = 0; i <= 52; i++) begin
                int t;
                t = (i == 52) ? c + 1 : i * 5;
                for (int ch = 0; ch < 2; ch++) begin
                    int exp_n, got, other, lastv;
                    clear_counts();
                    if (ch == 0) begin sup_wr = 1; sup_wd = {1'b0, W'(t)}; end
                    else begin hyp_wr = 1; hyp_wd = {1'b0, W'(t)}; end
                    step(c);
                    for (int k = 1; k <= 257; k++) step((c + k) % 256);
                    exp_n = (t > c) ? 1 : 0;
                    got   = (ch == 0) ? cnt_sup : cnt_hyp;
                    other = (ch == 0) ? cnt_hyp : cnt_sup;
                    lastv = (ch == 0) ? last_sup : last_hyp;
                    if (t > c) chk(got == 1, "R7 R3 fire once", got, 1);
                    else       chk(got == 0, "R4 not armed", got, 0);
                    if (exp_n == 1) chk(lastv == t, "R3 fire at target", lastv, t);
                    chk(other == 0, "R12 other channel quiet", other, 0);
                    chk(route_err == 0, (ch == 0) ? "R8 sup route" : "R9 hyp route", route_err, 0);
                end
            end
        end

        // R5: a disabling write cancels the armed target
        clear_counts();
        sup_wr = 1; sup_wd = {1'b0, 8'd20}; step(10);
        for (int v = 11; v <= 15; v++) step(v);
        sup_wr = 1; sup_wd = {1'b1, 8'd20}; step(16);
        for (int v = 17; v <= 40; v++) step(v);
        chk(cnt_sup == 0, "R5 disabled no pulse", cnt_sup, 0);

        // R6: a rewrite replaces the target
        clear_counts();
        sup_wr = 1; sup_wd = {1'b0, 8'd20}; step(10);
        step(11);
        sup_wr = 1; sup_wd = {1'b0, 8'd30}; step(12);
        for (int v = 13; v <= 40; v++) step(v);
        chk(cnt_sup == 1, "R6 one pulse", cnt_sup, 1);
        chk(last_sup == 30, "R6 new target", last_sup, 30);

        // R10 and R12: halted at equality; both channels target 20
        clear_counts();
        sup_wr = 1; sup_wd = {1'b0, 8'd20};
        hyp_wr = 1; hyp_wd = {1'b0, 8'd20}; step(10);
        for (int v = 11; v <= 18; v++) step(v);
        halted = 1;
        for (int v = 19; v <= 21; v++) step(v);
        halted = 0;
        for (int k = 22; k <= 22 + 260; k++) step(k % 256);
        chk(cnt_hyp == 0, "R10 halted no pulse", cnt_hyp, 0);
        chk(cnt_sup == 1 && last_sup == 20, "R10 sup unaffected", last_sup, 20);

        // R12: both channels fire in the same cycle
        clear_counts();
        sup_wr = 1; sup_wd = {1'b0, 8'd50};
        hyp_wr = 1; hyp_wd = {1'b0, 8'd50}; step(40);
        for (int v = 41; v <= 49; v++) step(v);
        tick = 8'd50;
        @(negedge clk);
        chk(match == 2'b11 && swint == (SW'(1) << SB) && hint,
            "R12 simultaneous", {match, hint}, 7);
        for (int v = 51; v <= 60; v++) step(v);

        // R11: a write in the equality cycle wins
        clear_counts();
        sup_wr = 1; sup_wd = {1'b0, 8'd20}; step(10);
        for (int v = 11; v <= 19; v++) step(v);
        sup_wr = 1; sup_wd = {1'b0, 8'd25}; step(20);
        chk(cnt_sup == 0, "R11 old target suppressed", cnt_sup, 0);
        for (int v = 21; v <= 40; v++) step(v);
        chk(cnt_sup == 1 && last_sup == 25, "R11 new target fires", last_sup, 25);

        // R11: a write of the current count in the equality cycle arms nothing
        clear_counts();
        hyp_wr = 1; hyp_wd = {1'b0, 8'd70}; step(60);
        for (int v = 61; v <= 69; v++) step(v);
        hyp_wr = 1; hyp_wd = {1'b0, 8'd70}; step(70);
        for (int k = 71; k <= 71 + 260; k++) step(k % 256);
        chk(cnt_hyp == 0, "R11 equal target not armed", cnt_hyp, 0);

        finish_up();
    end
endmodule